// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame addressed to a group (multicast) destination should be kept. The 48 destination address bits arrive one at a time, in wire order, each bit marked by a qualifier. As they arrive, the block runs a serial CRC-32 over them. Once the last address bit has been absorbed, it takes six high-order bits of the CRC register as an index into a 64-bit mask. The host loads that mask so that each bit enables one hash bucket.

A start strobe marks the beginning of each destination field. It presets the CRC and drops any partial address still in progress. One cycle after the 48th bit, the block produces a single-cycle valid pulse together with the accept flag. Addresses whose group bit is clear always get a reject, because exact individual-address matching and broadcast handling are done elsewhere.

Top module: `mcastHashFilter`

## Requirements
- R1: After reset, `matchValid` and `matchHit` are 0. Address bits offered before the first `startStrb` never lead to a `matchValid` pulse.
- R2: `startStrb` presets the CRC register to all ones and restarts the bit count. A partly received address is abandoned, and the result covers only the 48 bits that follow the strobe.
- R3: The CRC uses polynomial 0x04C11DB7. Address bit k (bit 0 first, as on the wire) is absorbed as: feedback = crc[31] XOR bit, then crc = (crc << 1) XOR (feedback ? 0x04C11DB7 : 0).
- R4: The filter index is crc[31:26], with crc[31] as the index MSB. It is taken from the CRC after all 48 bits.
- R5: For a group address (address bit 0, the first bit received, equal to 1), `matchHit` equals bit `index` of `filterMask`.
- R6: For an individual address (first received bit 0), `matchHit` is 0 while `matchValid` is 1.
- R7: `matchValid` is high for exactly one cycle. That cycle comes one clock after the edge that absorbs the 48th qualified bit; it is low in the cycle right after that edge.
- R8: `matchHit` is 0 whenever `matchValid` is 0.
- R9: Cycles with `bitValid` low do not advance the address. Bits offered after the 48th, with no new `startStrb`, are ignored and produce no further pulse.
- R10: An all-zero mask rejects every group address, and an all-ones mask accepts every group address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrb | input | 1 | Start of a destination address field; presets the CRC |
| bitValid | input | 1 | `bitIn` carries an address bit this cycle |
| bitIn | input | 1 | Serial address bit, wire order |
| filterMask | input | 64 | Host-loaded hash bucket enables |
| matchValid | output | 1 | One-cycle result strobe |
| matchHit | output | 1 | Accept decision, valid with `matchValid` |

## Verification
The assertions assume that `startStrb` and `bitValid` are never high in the same cycle when a bit is meant to count, and that `filterMask` is held steady around the evaluation cycle. The stimulus drives a start strobe alone in its own cycle, with `bitValid` low. Bits then follow with randomly inserted idle cycles, and the mask does not change until a frame's result has been checked. Directed runs cover the edges: an abandoned partial address, surplus bits after the 48th, and bits offered before any start.

// File: rtl/mcastHashPkg.sv
package mcastHashPkg;
  localparam logic [31:0] ETH_POLY = 32'h04C11DB7;

  typedef struct packed {
    logic preset;    // reload CRC with all ones
    logic shift;     // absorb bitIn
    logic firstBit;  // capture group bit
    logic evaluate;  // produce result this edge
  } ctrlStrobes_t;
endpackage

// File: rtl/mcastHashCtrl.sv
module mcastHashCtrl
  import mcastHashPkg::*;
#(
  parameter int ADDR_BITS = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startStrb,
  input  logic         bitValid,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(ADDR_BITS + 1);

  logic             active;
  logic [CNT_W-1:0] bitCount;
  logic             evalPending;
  logic             lastBit;

  always_comb begin
    strobes.preset   = startStrb;
    strobes.shift    = bitValid && active && !startStrb;
    strobes.firstBit = strobes.shift && (bitCount == '0);
    strobes.evaluate = evalPending;
    lastBit          = strobes.shift && (bitCount == CNT_W'(ADDR_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active      <= 1'b0;
      bitCount    <= '0;
      evalPending <= 1'b0;
    end else begin
      evalPending <= lastBit;
      if (startStrb) begin
        active   <= 1'b1;
        bitCount <= '0;
      end else if (strobes.shift) begin
        bitCount <= bitCount + 1'b1;
        if (lastBit) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mcastHashDatapath.sv
module mcastHashDatapath
  import mcastHashPkg::*;
#(
  parameter int          CRC_W = 32,
  parameter int          SEL_W = 6,
  parameter logic [CRC_W-1:0] POLY = ETH_POLY[CRC_W-1:0]
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic                  bitIn,
  input  logic [(1<<SEL_W)-1:0] filterMask,
  output logic                  matchValid,
  output logic                  matchHit
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcNext;
  logic [SEL_W-1:0] bucketSel;
  logic             groupBit;
  logic             feedback;

  always_comb begin
    feedback  = crcReg[CRC_W-1] ^ bitIn;
    crcNext   = {crcReg[CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    bucketSel = crcReg[CRC_W-1 -: SEL_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg     <= '1;
      groupBit   <= 1'b0;
      matchValid <= 1'b0;
      matchHit   <= 1'b0;
    end else begin
      if (strobes.preset)     crcReg <= '1;
      else if (strobes.shift) crcReg <= crcNext;
      if (strobes.preset)        groupBit <= 1'b0;
      else if (strobes.firstBit) groupBit <= bitIn;
      matchValid <= strobes.evaluate;
      matchHit   <= strobes.evaluate && groupBit && filterMask[bucketSel];
    end
  end
endmodule

// File: rtl/mcastHashFilter.sv
module mcastHashFilter
  import mcastHashPkg::*;
#(
  parameter int ADDR_BITS = 48,
  parameter int CRC_W     = 32,
  parameter int SEL_W     = 6,
  localparam int FILTER_W = 1 << SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startStrb,
  input  logic                bitValid,
  input  logic                bitIn,
  input  logic [FILTER_W-1:0] filterMask,
  output logic                matchValid,
  output logic                matchHit
);
  ctrlStrobes_t strobes;

  mcastHashCtrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStrb(startStrb),
    .bitValid(bitValid), .strobes(strobes)
  );

  mcastHashDatapath #(.CRC_W(CRC_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIn(bitIn),
    .filterMask(filterMask), .matchValid(matchValid), .matchHit(matchHit)
  );
endmodule

// File: rtl/mcastHashChecker.sv
module mcastHashChecker #(
  parameter int FILTER_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                bitValid,
  input logic [FILTER_W-1:0] filterMask,
  input logic                matchValid,
  input logic                matchHit
);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |=> !matchValid);

  assert_hit_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> matchValid);

  assert_zero_mask_rejects_R10: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && filterMask == '0) |-> !matchHit);

  assert_valid_follows_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> $past(bitValid, 2));
endmodule

bind mcastHashFilter mcastHashChecker #(.FILTER_W(FILTER_W)) u_checker (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .filterMask(filterMask),
  .matchValid(matchValid), .matchHit(matchHit)
);

// File: tb/mcastHashFilter_tb.sv
module mcastHashFilter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrb = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [63:0] filterMask = '0;
  logic        matchValid;
  logic        matchHit;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mcastHashFilter u_dut (
    .clk(clk), .rstN(rstN), .startStrb(startStrb), .bitValid(bitValid),
    .bitIn(bitIn), .filterMask(filterMask),
    .matchValid(matchValid), .matchHit(matchHit)
  );

  function automatic logic [31:0] refCrc(input logic [47:0] addr);
    logic [31:0] c = '1;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ addr[i];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [5:0] refIdx(input logic [47:0] addr);
    logic [31:0] c = refCrc(addr);
    return c[31:26];
  endfunction

  function automatic logic refHit(input logic [47:0] addr, input logic [63:0] m);
    return addr[0] & m[refIdx(addr)];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic doStart();
    @(negedge clk); startStrb = 1'b1; bitValid = 1'b0;
    @(negedge clk); startStrb = 1'b0;
  endtask

  task automatic sendBits(input logic [47:0] addr, input int nBits, input int gapPct);
    for (int i = 0; i < nBits; i++) begin
      while (($urandom % 100) < gapPct) begin
        bitValid = 1'b0; bitIn = $urandom % 2;
        @(negedge clk);
        check("R9 idle gap", matchValid, 1'b0);
      end
      bitValid = 1'b1; bitIn = addr[i];
      @(negedge clk);
    end
    bitValid = 1'b0;
  endtask

  // full frame; returns after the valid pulse has been checked
  task automatic runFrame(input logic [47:0] addr, input logic [63:0] m,
                          input int gapPct, input string req);
    filterMask = m;
    doStart();
    sendBits(addr, 48, gapPct);
    check("R7 low after last bit", matchValid, 1'b0);
    @(negedge clk);
    check("R7 valid pulse", matchValid, 1'b1);
    check(req, matchHit, refHit(addr, m));
    @(negedge clk);
    check("R7 one cycle", matchValid, 1'b0);
    check("R8 hit low", matchHit, 1'b0);
  endtask

  initial begin
    logic [47:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", matchValid, 1'b0);
    check("R1 reset hit", matchHit, 1'b0);
    rstN = 1'b1;
    // bits before any start
    sendBits(48'hFFFF_FFFF_FFFF, 48, 0);
    sendBits(48'h0123_4567_89AB, 10, 0);
    repeat (3) begin
      @(negedge clk);
      check("R1 no start no result", matchValid, 1'b0);
    end
    // R10 all-ones / all-zero mask on group addresses
    runFrame(48'hFFFF_FFFF_FFFF, '1, 0, "R10 all ones accept");
    runFrame(48'hFFFF_FFFF_FFFF, '0, 0, "R10 all zero reject");
    runFrame(48'h0000_5E00_0001, '1, 0, "R10 all ones accept");
    // R6 individual address with all-ones mask
    runFrame(48'h1234_5678_9A00, '1, 0, "R6 individual rejected");
    check("R6 hit low explicit", refHit(48'h1234_5678_9A00, '1), 1'b0);
    // R4/R5 single bucket selection
    a = 48'h0000_5E00_0001;
    runFrame(a, 64'd1 << refIdx(a), 2, "R4 single bucket hit");
    runFrame(a, ~(64'd1 << refIdx(a)), 2, "R4 other buckets miss");
    // R2 abandoned partial address
    filterMask = 64'd1 << refIdx(a);
    doStart();
    sendBits(48'hFFFF_FFFF_FFFF, 20, 0);
    runFrame(a, 64'd1 << refIdx(a), 0, "R2 restart hit");
    // R9 surplus bits after 48th
    runFrame(48'h3333_0000_0001, '1, 0, "R3 crc frame");
    sendBits(48'hFFFF_FFFF_FFFF, 30, 0);
    repeat (3) begin
      @(negedge clk);
      check("R9 surplus bits ignored", matchValid, 1'b0);
    end
    // random group/individual addresses, masks and gaps
    for (int n = 0; n < 80; n++) begin
      logic [63:0] m;
      a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (n % 4 != 3) a[0] = 1'b1;
      m = {$urandom, $urandom};
      runFrame(a, m, 25, "R3 R5 random frame");
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule